// File: doc/BRIEF.md
# Whitened Hopping Packet Framer

This block turns one frame of 16-bit audio samples into a single radio packet and passes it out a byte at a time through a valid/ready handshake to a downstream modulator. A packet is made of a run of 0xAA training bytes, a fixed 32-bit sync word, a length byte, a device address byte, the sample payload and a 16-bit check value. The check value is calculated over the clear bytes. Every byte from the length byte through the check value then leaves XOR-masked by a PN9 whitening sequence.

The payload is fetched through a combinational read port. The framer puts a sample index on `smp_idx`, and the surrounding logic returns that sample on `smp_data`, normally from whichever audio buffer is currently inactive. One start pulse is issued per audio frame (96 samples, so every 6 ms at 16 kHz).

After each packet the framer steps a hop index through four positions. It presents the channel number to tune as band × 4 + hop, where the band is taken from a three-position selector when the packet starts. Carrier frequency synthesis from the channel number lies outside this block.

Top module: `hop_packet_framer`

## Requirements
- R1: After reset `tx_valid` and `tx_last` are low and `chan` is 0.
- R2: A `start` pulse while idle begins a packet. Its first eight bytes leave unwhitened: four bytes of 0xAA, then the sync word most significant byte first (default D3 91 D3 91).
- R3: Byte 8 is the length, equal to the payload byte count plus one (the address byte). The default value is 193 (0xC1). Byte 9 is `dev_addr` as it was latched at the start pulse.
- R4: The payload carries the samples at indices 0 to NSAMP-1 in order, read through `smp_idx`/`smp_data`, with the high byte of each sample first.
- R5: The last two bytes are the check value, high byte first. It is a CRC-16 with polynomial 0x8005, initial value 0xFFFF, message bits processed most significant first and no final inversion, computed over the clear length, address and payload bytes.
- R6: The length byte through the second check byte are XORed with bits [7:0] of a 9-bit PN9 register. The register is set to all ones at every packet start. After each masked byte it takes eight steps, and each step shifts right with bit0 XOR bit5 entering at bit8.
- R7: A byte and `tx_valid` are held until `tx_ready` is high. Each accepted cycle advances exactly one byte. `tx_last` marks the final byte, and `tx_valid` is low in the cycle after it is accepted.
- R8: `start` has no effect while a packet is in progress, including the cycle in which the final byte is accepted.
- R9: `chan` equals band × 4 + hop. The band is latched at the start pulse. The hop advances modulo 4 when the final byte of each packet is accepted.
- R10: `band_sel` values above 2 select band 2, so `chan` never exceeds 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet (idle only) |
| band_sel | input | 2 | Band selector, latched at start |
| dev_addr | input | 8 | Device address, latched at start |
| smp_idx | output | 7 | Index of the sample being read |
| smp_data | input | 16 | Sample at `smp_idx` |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_last | output | 1 | Final byte of packet |
| chan | output | 4 | Channel number to tune |

## Verification
Two events can fall in the same clock edge: acceptance of the final check byte, which advances the hop index and ends the packet, and a new `start` request. The bench raises `start` exactly in the cycle where the last byte is handed over, and also once in the middle of the payload. It then requires that the byte stream matches the independently computed packet, that `tx_valid` falls on the next cycle, and that `chan` shows only the single hop step with no new packet begun. A separate run drives stalls on `tx_ready` across a full packet, so that held bytes and whitening/CRC advance can be judged against back-pressure.

// File: rtl/hop_packet_framer.sv
module hop_packet_framer #(
  parameter int          NSAMP     = 96,
  parameter logic [31:0] SYNC_WORD = 32'hD391D391,
  parameter int          NBANDS    = 3,
  parameter int          HOPS      = 4,
  localparam int         IW        = $clog2(NSAMP),
  localparam int         BW        = $clog2(NBANDS),
  localparam int         CW        = $clog2(NBANDS * HOPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] band_sel,
  input  logic [7:0]    dev_addr,
  output logic [IW-1:0] smp_idx,
  input  logic [15:0]   smp_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic [CW-1:0] chan
);
  localparam int PLD   = 2 * NSAMP;
  localparam int TOTAL = 12 + PLD;
  localparam int PW    = $clog2(TOTAL);
  localparam int HW    = $clog2(HOPS);
  localparam logic [PW-1:0] P_SYNC = PW'(4);
  localparam logic [PW-1:0] P_LEN  = PW'(8);
  localparam logic [PW-1:0] P_ADDR = PW'(9);
  localparam logic [PW-1:0] P_PAY  = PW'(10);
  localparam logic [PW-1:0] P_CRC  = PW'(10 + PLD);
  localparam logic [PW-1:0] P_END  = PW'(TOTAL - 1);
  localparam logic [7:0]    LEN_V  = 8'(PLD + 1);

  function automatic logic [8:0] pn9_adv(input logic [8:0] s);
    for (int i = 0; i < 8; i++) s = {s[0] ^ s[5], s[8:1]};
    return s;
  endfunction

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  logic          busy;
  logic [PW-1:0] pos;
  logic [8:0]    lfsr;
  logic [15:0]   crc;
  logic [HW-1:0] hop;
  logic [BW-1:0] band_q;
  logic [7:0]    addr_q;
  logic [7:0]    clear;
  logic [PW-1:0] off;
  logic [BW-1:0] band_in;

  assign band_in  = (int'(band_sel) >= NBANDS) ? BW'(NBANDS - 1) : band_sel;
  assign off      = pos - P_PAY;
  assign smp_idx  = (pos >= P_PAY && pos < P_CRC) ? IW'(off >> 1) : '0;
  assign tx_valid = busy;
  assign tx_last  = busy && (pos == P_END);
  assign tx_data  = clear ^ ((pos >= P_LEN) ? lfsr[7:0] : 8'h00);
  assign chan     = CW'(int'(band_q) * HOPS + int'(hop));

  always_comb begin
    if (pos < P_SYNC)       clear = 8'hAA;
    else if (pos < P_LEN)   clear = 8'(SYNC_WORD >> {3'd7 - pos[2:0], 3'b000});
    else if (pos == P_LEN)  clear = LEN_V;
    else if (pos == P_ADDR) clear = addr_q;
    else if (pos < P_CRC)   clear = off[0] ? smp_data[7:0] : smp_data[15:8];
    else if (pos == P_CRC)  clear = crc[15:8];
    else                    clear = crc[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pos    <= '0;
      lfsr   <= 9'h1FF;
      crc    <= 16'hFFFF;
      hop    <= '0;
      band_q <= '0;
      addr_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        pos    <= '0;
        lfsr   <= 9'h1FF;
        crc    <= 16'hFFFF;
        band_q <= band_in;
        addr_q <= dev_addr;
      end
    end else if (tx_ready) begin
      if (pos >= P_LEN) lfsr <= pn9_adv(lfsr);
      if (pos >= P_LEN && pos < P_CRC) crc <= crc_upd(crc, clear);
      if (pos == P_END) begin
        busy <= 1'b0;
        hop  <= (int'(hop) == HOPS - 1) ? '0 : hop + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

module hop_packet_framer_chk #(
  parameter int NBANDS = 3,
  parameter int HOPS   = 4,
  localparam int CW    = $clog2(NBANDS * HOPS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_last,
  input logic [CW-1:0] chan
);
  logic fin, go;
  assign fin = tx_valid && tx_ready && tx_last;
  assign go  = start && !tx_valid;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !tx_valid);
  assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> tx_valid && tx_data == 8'hAA);
  assert_hop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> int'(chan) % HOPS == (int'($past(chan)) % HOPS + 1) % HOPS);
  assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !fin |=> $stable(chan));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && start && !fin |=> tx_valid);
  assert_chan_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chan) < NBANDS * HOPS);
endmodule

bind hop_packet_framer hop_packet_framer_chk #(.NBANDS(NBANDS), .HOPS(HOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_last(tx_last), .chan(chan)
);

// File: tb/hop_packet_framer_tb.sv
module hop_packet_framer_tb;
  localparam int NS    = 96;
  localparam int TOTAL = 12 + 2 * NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  band_sel = 2'd0;
  logic [7:0]  dev_addr = 8'd0;
  logic [6:0]  smp_idx;
  logic [15:0] smp_data;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        tx_last;
  logic [3:0]  chan;

  logic [15:0] smem [NS];
  logic [7:0]  exp_b [TOTAL];
  int checks = 0, fails = 0, hop_m = 0;

  assign smp_data = (int'(smp_idx) < NS) ? smem[smp_idx] : 16'h0000;

  always #5 clk = ~clk;

  hop_packet_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .band_sel(band_sel), .dev_addr(dev_addr),
    .smp_idx(smp_idx), .smp_data(smp_data), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .chan(chan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int n);
    if (n < 8) return "R2 preamble/sync";
    if (n < 10) return "R3 length/addr (R6 whitened)";
    if (n < 10 + 2 * NS) return "R4 payload (R6 whitened)";
    return "R5 crc (R6 whitened)";
  endfunction

  task automatic fill(input logic [15:0] seed, input logic [15:0] step);
    for (int i = 0; i < NS; i++) smem[i] = seed + 16'(i) * step;
  endtask

  task automatic build(input logic [7:0] a);
    logic [7:0]  clr [TOTAL];
    logic [15:0] c;
    logic [8:0]  w;
    for (int i = 0; i < 4; i++) clr[i] = 8'hAA;
    clr[4] = 8'hD3; clr[5] = 8'h91; clr[6] = 8'hD3; clr[7] = 8'h91;
    clr[8] = 8'd193;
    clr[9] = a;
    for (int i = 0; i < NS; i++) begin
      clr[10 + 2 * i]     = smem[i][15:8];
      clr[10 + 2 * i + 1] = smem[i][7:0];
    end
    c = 16'hFFFF;
    for (int k = 8; k < 10 + 2 * NS; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ clr[k][b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    clr[TOTAL - 2] = c[15:8];
    clr[TOTAL - 1] = c[7:0];
    w = 9'h1FF;
    for (int k = 0; k < TOTAL; k++) begin
      if (k < 8) exp_b[k] = clr[k];
      else begin
        exp_b[k] = clr[k] ^ w[7:0];
        for (int s = 0; s < 8; s++) w = {w[0] ^ w[5], w[8:1]};
      end
    end
  endtask

  task automatic send_packet(input logic [7:0] a, input logic [1:0] bs, input int stall, input bit poke);
    int n = 0, guard = 0, eb;
    eb = (bs > 2) ? 2 : int'(bs);
    build(a);
    @(negedge clk); start = 1'b1; band_sel = bs; dev_addr = a; tx_ready = 1'b0;
    @(negedge clk); start = 1'b0; band_sel = ~bs; dev_addr = ~a;
    #1 chk(int'(chan) == eb * 4 + hop_m, "R9/R10 chan at start", chan, eb * 4 + hop_m);
    while (n < TOTAL && guard < 3000) begin
      tx_ready = (stall == 0) || (guard % stall != 0);
      start = poke && (n == 100 || n == TOTAL - 1);
      #1;
      if (!tx_valid) chk(0, "R7 valid during packet", 0, 1);
      else if (tx_ready) begin
        chk(tx_data == exp_b[n], tag_of(n), tx_data, exp_b[n]);
        chk(tx_last == (n == TOTAL - 1), "R7 last flag", tx_last, n == TOTAL - 1);
        n++;
      end
      @(negedge clk); guard++;
    end
    start = 1'b0; tx_ready = 1'b1;
    #1;
    chk(n == TOTAL, "R7 byte count", n, TOTAL);
    chk(!tx_valid, poke ? "R8 start at final byte ignored" : "R7 idle after last", tx_valid, 0);
    hop_m = (hop_m + 1) % 4;
    chk(int'(chan) == eb * 4 + hop_m, "R9 hop advance", chan, eb * 4 + hop_m);
    repeat (2) @(negedge clk);
    chk(!tx_valid, "R8 no packet begun", tx_valid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && !tx_last, "R1 outputs idle", {tx_valid, tx_last}, 0);
    chk(chan == 4'd0, "R1 chan zero", chan, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;    fill(16'h1234, 16'h0133); send_packet(8'h5A, 2'd0, 0, 1'b0); endtask
  task automatic t_stall;    fill(16'hFF00, 16'h7F01); send_packet(8'hC3, 2'd1, 3, 1'b0); endtask
  task automatic t_clamp;    fill(16'h0000, 16'h0000); send_packet(8'h00, 2'd3, 0, 1'b0); endtask
  task automatic t_busy;     fill(16'h8001, 16'h0101); send_packet(8'h11, 2'd2, 2, 1'b1); endtask
  task automatic t_hop_wrap; fill(16'h00FF, 16'h0001); send_packet(8'h7E, 2'd0, 0, 1'b0); endtask

  initial begin
    t_reset;
    t_basic;
    t_stall;
    t_clamp;
    t_busy;
    t_hop_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule